// File: doc/BRIEF.md
# Packet Receive Phase Sequencer

This controller walks an impulse-radio receiver through the reception of a single packet. While nothing is happening it holds the baseband datapath power-gated and the analog front-end off. A wake request starts a packet. The front-end is turned on and power gating is released. A programmable settling interval then runs before the correlator bank is told to hunt for the preamble. The preamble is a train of repeated 31-chip Gold-code symbols.

Once the correlator reports a peak, the sequencer enables channel estimation and then payload demodulation. Demodulation delivers four bits on every valid cycle. When the programmed number of payload bits has arrived, the receiver is switched off and the datapath goes back to sleep. Acquisition has a bound: a repetition strobe marks each Gold-code period, and if no peak arrives within a programmed number of repetitions, the packet is abandoned. In that case the front-end is powered down at once and a failure pulse is raised.

The block is meant to sit next to the correlator bank and the combiners, running on their 25 MHz core clock. It drives their phase enables and the power-gating control.

Top module: `rx_phase_seq`

## Requirements
- R1: After reset, `sleepCtl` is 1, and `rxOn`, `acqEn`, `estEn`, `demodEn`, `acqFail` and `pktDone` are all 0.
- R2: A `wakeReq` sampled while idle sets `rxOn`=1 and `sleepCtl`=0 from the next cycle. The block then stays in recovery, with no phase enable, for exactly `recoveryCycles`+1 cycles before `acqEn` rises.
- R3: Phases follow a fixed order. Acquisition is followed by estimation once `acqDone` is sampled during acquisition. Estimation is followed by demodulation once `estDone` is sampled during estimation. At most one of `acqEn`, `estEn` and `demodEn` is 1 in any cycle.
- R4: During acquisition, each `repTick` counts one Gold-code repetition. If the count reaches `maxReps` (a value of 0 behaves like 1) while `acqDone` is low, the block returns to idle. In that case `rxOn` falls, `sleepCtl` rises, and `acqFail` is 1 for exactly the first idle cycle.
- R5: If `acqDone` and the repetition that would reach `maxReps` are sampled in the same cycle, the peak wins. The block enters estimation and does not raise `acqFail`.
- R6: During demodulation, each sampled `bitValid` adds 4 to a bit count that starts at 0. The valid that brings the count to at least `payloadLen` ends the packet. Demodulation therefore lasts ceil(`payloadLen`/4) valid cycles, with a minimum of 1. The block then returns to idle, and `pktDone` is 1 for exactly the first idle cycle.
- R7: A `wakeReq` sampled while not idle has no effect. The current packet runs to its normal end, and the block then stays idle.
- R8: `acqDone`, `estDone`, `repTick` and `bitValid` have no effect outside their own phase. Counts made in one packet do not carry into the next.
- R9: In every cycle, `sleepCtl` is the inverse of `rxOn`. While `sleepCtl` is 1, no phase enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeReq | input | 1 | Request to receive a packet |
| acqDone | input | 1 | Correlation peak found |
| estDone | input | 1 | Channel estimate ready |
| repTick | input | 1 | One Gold-code repetition elapsed |
| bitValid | input | 1 | Four demodulated bits delivered this cycle |
| payloadLen | input | LEN_W | Payload length in bits |
| recoveryCycles | input | REC_W | Settling cycles after gating release, minus one |
| maxReps | input | REP_W | Repetition budget for acquisition |
| sleepCtl | output | 1 | Power-gating control, 1 = datapath asleep |
| rxOn | output | 1 | Front-end and converter power |
| acqEn | output | 1 | Acquisition phase enable |
| estEn | output | 1 | Channel estimation enable |
| demodEn | output | 1 | Demodulation enable |
| acqFail | output | 1 | One-cycle pulse: acquisition abandoned |
| pktDone | output | 1 | One-cycle pulse: payload complete |

## Verification
Two acquisition outcomes can be decided in the same cycle: a peak report and the repetition that exhausts the budget. The bench provokes this by holding `repTick` high throughout acquisition and raising `acqDone` so that it is sampled together with the last allowed tick. It then requires a transition to estimation after exactly `maxReps` acquisition cycles, with no `acqFail` pulse at any time. A separate packet with the same tick pattern and no peak must produce the abort, which shows that the race is decided by `acqDone` and not by the repetition count.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RECOVER = 3'd1,
    PH_ACQ     = 3'd2,
    PH_EST     = 3'd3,
    PH_DEMOD   = 3'd4
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic recStep;
    logic acqCount;
    logic demodCount;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic recDone;
    logic repLimit;
    logic lenReached;
  } seqStatus_t;

endpackage

// File: rtl/rxseq_dp.sv
module rxseq_dp
  import rxseq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int REC_W = 8,
  parameter int REP_W = 6,
  parameter int BITS_PER_VALID = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             repTick,
  input  logic             bitValid,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic [REC_W-1:0] recoveryCycles,
  input  logic [REP_W-1:0] maxReps,
  output seqStatus_t       status
);

  localparam int BIT_W = LEN_W + 1;
  localparam int RCNT_W = REP_W + 1;
  localparam logic [BIT_W-1:0] BIT_STEP = BIT_W'(BITS_PER_VALID);

  logic [REC_W-1:0]  recCnt;
  logic [RCNT_W-1:0] repCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [RCNT_W-1:0] repNext;
  logic [BIT_W-1:0]  bitNext;

  assign repNext = repCnt + RCNT_W'(1);
  assign bitNext = bitCnt + BIT_STEP;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      recCnt <= '0;
      repCnt <= '0;
      bitCnt <= '0;
    end else begin
      if (strobe.recStep && recCnt != recoveryCycles) recCnt <= recCnt + REC_W'(1);
      if (strobe.acqCount && repTick) repCnt <= repNext;
      if (strobe.demodCount && bitValid) bitCnt <= bitNext;
    end
  end

  always_comb begin
    status.recDone    = strobe.recStep && (recCnt >= recoveryCycles);
    status.repLimit   = strobe.acqCount && repTick &&
                        (repNext >= {1'b0, maxReps});
    status.lenReached = strobe.demodCount && bitValid &&
                        (bitNext >= {1'b0, payloadLen});
  end

endmodule

// File: rtl/rxseq_ctrl.sv
module rxseq_ctrl
  import rxseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeReq,
  input  logic       acqDone,
  input  logic       estDone,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       sleepCtl,
  output logic       rxOn,
  output logic       acqEn,
  output logic       estEn,
  output logic       demodEn,
  output logic       acqFail,
  output logic       pktDone
);

  phase_t phase, phaseNext;
  logic failNext, doneNext;

  always_comb begin
    phaseNext = phase;
    failNext  = 1'b0;
    doneNext  = 1'b0;
    unique case (phase)
      PH_IDLE:    if (wakeReq) phaseNext = PH_RECOVER;
      PH_RECOVER: if (status.recDone) phaseNext = PH_ACQ;
      PH_ACQ: begin
        if (acqDone) phaseNext = PH_EST;           // peak beats budget
        else if (status.repLimit) begin
          phaseNext = PH_IDLE;
          failNext  = 1'b1;
        end
      end
      PH_EST:     if (estDone) phaseNext = PH_DEMOD;
      PH_DEMOD: begin
        if (status.lenReached) begin
          phaseNext = PH_IDLE;
          doneNext  = 1'b1;
        end
      end
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      acqFail <= 1'b0;
      pktDone <= 1'b0;
    end else begin
      phase   <= phaseNext;
      acqFail <= failNext;
      pktDone <= doneNext;
    end
  end

  always_comb begin
    strobe.clrAll     = (phase == PH_IDLE);
    strobe.recStep    = (phase == PH_RECOVER);
    strobe.acqCount   = (phase == PH_ACQ);
    strobe.demodCount = (phase == PH_DEMOD);
    sleepCtl = (phase == PH_IDLE);
    rxOn     = (phase != PH_IDLE);
    acqEn    = (phase == PH_ACQ);
    estEn    = (phase == PH_EST);
    demodEn  = (phase == PH_DEMOD);
  end

endmodule

// File: rtl/rx_phase_seq.sv
module rx_phase_seq
  import rxseq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int REC_W = 8,
  parameter int REP_W = 6,
  parameter int BITS_PER_VALID = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeReq,
  input  logic             acqDone,
  input  logic             estDone,
  input  logic             repTick,
  input  logic             bitValid,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic [REC_W-1:0] recoveryCycles,
  input  logic [REP_W-1:0] maxReps,
  output logic             sleepCtl,
  output logic             rxOn,
  output logic             acqEn,
  output logic             estEn,
  output logic             demodEn,
  output logic             acqFail,
  output logic             pktDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  rxseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .acqDone(acqDone),
    .estDone(estDone), .status(status), .strobe(strobe),
    .sleepCtl(sleepCtl), .rxOn(rxOn), .acqEn(acqEn), .estEn(estEn),
    .demodEn(demodEn), .acqFail(acqFail), .pktDone(pktDone)
  );

  rxseq_dp #(
    .LEN_W(LEN_W), .REC_W(REC_W), .REP_W(REP_W), .BITS_PER_VALID(BITS_PER_VALID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .repTick(repTick),
    .bitValid(bitValid), .payloadLen(payloadLen),
    .recoveryCycles(recoveryCycles), .maxReps(maxReps), .status(status)
  );

endmodule

// File: rtl/rx_phase_seq_chk.sv
module rx_phase_seq_chk (
  input logic clk,
  input logic rstN,
  input logic acqDone,
  input logic sleepCtl,
  input logic rxOn,
  input logic acqEn,
  input logic estEn,
  input logic demodEn,
  input logic acqFail,
  input logic pktDone
);

  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleepCtl |-> !(rxOn || acqEn || estEn || demodEn));

  a_r3_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acqEn, estEn, demodEn}));

  a_r3_est_after_acq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(estEn) |-> $past(acqEn) && $past(acqDone));

  a_r3_demod_after_est: assert property (@(posedge clk) disable iff (!rstN)
    $rose(demodEn) |-> $past(estEn));

  a_r2_acq_after_power: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acqEn) |-> $past(rxOn) && !$past(sleepCtl));

  a_r4_fail_powers_down: assert property (@(posedge clk) disable iff (!rstN)
    acqFail |-> $past(acqEn) && !rxOn && sleepCtl);

  a_r4_fail_single: assert property (@(posedge clk) disable iff (!rstN)
    acqFail |=> !acqFail);

  a_r5_no_fail_on_peak: assert property (@(posedge clk) disable iff (!rstN)
    acqEn && acqDone |=> !acqFail && estEn);

  a_r6_done_from_demod: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> $past(demodEn) && sleepCtl);

endmodule

bind rx_phase_seq rx_phase_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .acqDone(acqDone), .sleepCtl(sleepCtl),
  .rxOn(rxOn), .acqEn(acqEn), .estEn(estEn), .demodEn(demodEn),
  .acqFail(acqFail), .pktDone(pktDone)
);

// File: tb/rx_phase_seq_tb_top.sv
module rx_phase_seq_tb_top;

  localparam int LEN_W = 12;
  localparam int REC_W = 8;
  localparam int REP_W = 6;

  // observed word: {sleepCtl, rxOn, acqEn, estEn, demodEn, acqFail, pktDone}
  localparam logic [6:0] W_IDLE = 7'b1000000;
  localparam logic [6:0] W_REC  = 7'b0100000;
  localparam logic [6:0] W_ACQ  = 7'b0110000;
  localparam logic [6:0] W_EST  = 7'b0101000;
  localparam logic [6:0] W_DEM  = 7'b0100100;
  localparam logic [6:0] W_FAIL = 7'b1000010;
  localparam logic [6:0] W_DONE = 7'b1000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeReq = 1'b0, acqDone = 1'b0, estDone = 1'b0, repTick = 1'b0, bitValid = 1'b0;
  logic [LEN_W-1:0] payloadLen = '0;
  logic [REC_W-1:0] recoveryCycles = '0;
  logic [REP_W-1:0] maxReps = '0;
  logic sleepCtl, rxOn, acqEn, estEn, demodEn, acqFail, pktDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [6:0] word;
    int unsigned dwell;   // cycles the previous word must have lasted, 0 = any
    logic [7:0] req;      // requirement number for messages
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  rx_phase_seq #(.LEN_W(LEN_W), .REC_W(REC_W), .REP_W(REP_W)) dut_i (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .acqDone(acqDone),
    .estDone(estDone), .repTick(repTick), .bitValid(bitValid),
    .payloadLen(payloadLen), .recoveryCycles(recoveryCycles), .maxReps(maxReps),
    .sleepCtl(sleepCtl), .rxOn(rxOn), .acqEn(acqEn), .estEn(estEn),
    .demodEn(demodEn), .acqFail(acqFail), .pktDone(pktDone)
  );

  wire [6:0] obs = {sleepCtl, rxOn, acqEn, estEn, demodEn, acqFail, pktDone};

  task automatic expect_(input logic [6:0] w, input int unsigned d, input int r);
    expQ.push_back('{word: w, dwell: d, req: 8'(r)});
  endtask

  // monitor: compares every change of the output word against the queue
  logic [6:0] lastWord = W_IDLE;
  int unsigned dwellCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (obs !== lastWord) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected change: actual=%b expected=%b (no change)", obs, lastWord);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (obs !== e.word || (e.dwell != 0 && dwellCnt != e.dwell)) begin
            failures++;
            $display("FAIL R%0d word=%b dwell=%0d expected word=%b dwell=%0d",
                     e.req, obs, dwellCnt, e.word, e.dwell);
          end
        end
        lastWord = obs;
        dwellCnt = 1;
      end else begin
        dwellCnt++;
      end
    end
  end

  task automatic waitWord(input logic [6:0] w);
    do @(negedge clk); while (obs !== w);
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeReq = 1'b1;
    @(negedge clk); wakeReq = 1'b0;
  endtask

  task automatic drain(input int cyc);
    repeat (cyc) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R3 pending expectations: actual=%0d expected=0", expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    checks++;
    if (obs !== W_IDLE) begin
      failures++;
      $display("FAIL R1 reset word actual=%b expected=%b", obs, W_IDLE);
    end
    rstN = 1'b1;
    @(negedge clk);

    // Packet 1 (R2 R3 R6 R7 R8): recovery 3 -> 4 cycles, estDone held (ignored
    // until estimation, then estimation lasts 1), bitValid held from start,
    // length 20 -> 5 valids, wake pulsed during demodulation.
    recoveryCycles = 8'd3; maxReps = 6'd8; payloadLen = 12'd20;
    estDone = 1'b1; bitValid = 1'b1;
    expect_(W_REC, 0, 2);
    expect_(W_ACQ, 4, 2);
    expect_(W_EST, 3, 3);
    expect_(W_DEM, 1, 8);
    expect_(W_DONE, 5, 6);
    expect_(W_IDLE, 1, 6);
    pulseWake();
    waitWord(W_ACQ);
    repeat (2) @(negedge clk);
    acqDone = 1'b1;
    @(negedge clk); acqDone = 1'b0;
    waitWord(W_DEM);
    wakeReq = 1'b1;             // R7: ignored while busy
    @(negedge clk); wakeReq = 1'b0;
    waitWord(W_IDLE);
    estDone = 1'b0; bitValid = 1'b0;
    drain(12);

    // Packet 2 (R4): no peak, repTick every cycle, budget 3
    recoveryCycles = 8'd0; maxReps = 6'd3; repTick = 1'b1;
    expect_(W_REC, 0, 2);
    expect_(W_ACQ, 1, 2);
    expect_(W_FAIL, 3, 4);
    expect_(W_IDLE, 1, 4);
    pulseWake();
    waitWord(W_IDLE);
    drain(6);

    // Packet 3 (R5): same ticks, budget 2, peak on the last allowed tick;
    // length 8 -> 2 valids, bitValid held
    maxReps = 6'd2; payloadLen = 12'd8; bitValid = 1'b1;
    expect_(W_REC, 0, 2);
    expect_(W_ACQ, 1, 2);
    expect_(W_EST, 2, 5);
    expect_(W_DEM, 2, 3);
    expect_(W_DONE, 2, 6);
    expect_(W_IDLE, 1, 6);
    pulseWake();
    waitWord(W_ACQ);
    @(negedge clk);
    acqDone = 1'b1;
    @(negedge clk); acqDone = 1'b0;
    @(negedge clk); estDone = 1'b1;
    @(negedge clk); estDone = 1'b0;
    waitWord(W_IDLE);
    repTick = 1'b0; bitValid = 1'b0;
    drain(6);

    // Packet 4 (R6 R8): length 1, sparse valids, budget 0 never hit (no ticks)
    recoveryCycles = 8'd5; maxReps = 6'd0; payloadLen = 12'd1;
    expect_(W_REC, 0, 2);
    expect_(W_ACQ, 6, 2);
    expect_(W_EST, 1, 3);
    expect_(W_DEM, 1, 3);
    expect_(W_DONE, 4, 6);
    expect_(W_IDLE, 1, 6);
    pulseWake();
    waitWord(W_ACQ);
    acqDone = 1'b1;
    @(negedge clk); acqDone = 1'b0; estDone = 1'b1;
    @(negedge clk); estDone = 1'b0;
    repeat (3) @(negedge clk);
    bitValid = 1'b1;
    @(negedge clk); bitValid = 1'b0;
    waitWord(W_IDLE);
    drain(6);

    // R9: idle word persists
    checks++;
    if (obs !== W_IDLE) begin
      failures++;
      $display("FAIL R9 idle word actual=%b expected=%b", obs, W_IDLE);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL R3 watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule